// File: doc/BRIEF.md
# Clock-framed 15-bit serial deserializer

This block turns a single serial data line into parallel 15-bit words. It runs on a fast clock at fifteen times the frame rate and captures one data bit on every edge of that clock. On the same edge it takes an already synchronous sample of the slow frame clock. A frame begins on a rising edge of that sampled clock, and each frame holds bits 0 to 14. The frame clock has an uneven shape: eight samples high followed by seven samples low. The block checks every frame against that shape.

Each finished word appears on a parallel output, bit 0 in the least significant place, together with a one-cycle strobe. A framing error is a pulse that lasts one cycle. When one occurs, the block drops the word in progress. If the error was an early rising edge, the block realigns on that edge; otherwise it waits for the next rising edge. A lock flag reports that the frame stream is steady.

The control is a four-state machine:
- `ST_HUNT` waits for the first rising edge after reset or after a shape error.
- `ST_ALIGN0` means the block is aligned but has no good word yet.
- `ST_ALIGN1` means one good word has been received.
- `ST_LOCKED` means two or more consecutive good words have been received.

The transitions are:
- Hunt to align0: on a rising edge.
- Align0 to align1, and align1 to locked: on each completed word.
- Any aligned state to align0: on an early rising edge.
- Any aligned state to hunt: on a shape error.
- Locked to locked: on every further good word.

Every register stays one compare deep so that the block can run at a 300 MHz bit clock.

Top module: `clkframe_deser`

## Requirements
- R1: Synchronous active-high reset clears word_o to 0 and clears word_valid_o, frame_err_o and locked_o to 0. A frame-clock sample of 1 in the first cycle after reset does not count as a rising edge.
- R2: A rising edge is a sample of 1 after a sample of 0, and that sample is taken as bit 0. Before the first rising edge (state hunt), no word and no framing error is reported, whatever the frame-clock pattern.
- R3: The block samples bit 14, which is the fifteenth sample counting the rising-edge sample as the first. On the next cycle word_o holds the frame's bits with bit n in word_o[n], and word_valid_o is 1 for exactly that one cycle.
- R4: Within a frame, sample positions 0 to 7 must be high and positions 8 to 14 must be low. A low sample at positions 1 to 7, or a high sample at position 8, raises frame_err_o. No word is produced for that frame, and the block returns to hunt.
- R5: A rising edge at a position other than 15 (that is, at positions 9 to 14) raises frame_err_o. The block restarts the frame with that sample as bit 0, and that frame's word is delivered normally.
- R6: A sixteenth sample in a frame that is still low raises frame_err_o and sends the block to hunt.
- R7: frame_err_o is 1 only on the cycle after the offending sample. It is never 1 together with word_valid_o.
- R8: locked_o rises on the same cycle as the second consecutive word strobe after alignment. It falls on the same cycle as any framing error.
- R9: word_o holds its value between word strobes.
- R10: A frame-clock sample that is still high after position 7 (a high run longer than eight) is reported at position 8 as in R4. It never produces a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, fifteen times the frame rate |
| rst | input | 1 | Synchronous active-high reset |
| fclk_smp_i | input | 1 | Synchronous sample of the frame clock level |
| sdata_i | input | 1 | Serial data bit for this cycle |
| word_o | output | 15 | Last assembled word, bit 0 in the LSB |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| frame_err_o | output | 1 | One-cycle framing error pulse |
| locked_o | output | 1 | Two or more consecutive good frames seen |

## Verification
The bench drives clean frames carrying a walking one across all fifteen bit positions. This shows that each bit lands in the right place in the word. It also drives all-zero, all-one, alternating and arithmetically generated words, which expose stuck or swapped bits.

The bench sweeps the falling edge of the frame clock over every early position and one late position. It sweeps the rising edge over every early position from 9 to 14, and it adds one frame with an overlong low phase. Together these sweeps separate the two error routes: realignment on the offending edge, and falling back to hunt. After each error the bench checks that lock takes exactly two good frames to return.

A run of steady high and then steady low samples straight after reset shows that hunting raises no error. A reset in the middle of a frame shows that every output clears.

// File: rtl/clkframe_deser_pkg.sv
package clkframe_deser_pkg;

    // Alignment state machine
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_ALIGN0 = 2'd1,
        ST_ALIGN1 = 2'd2,
        ST_LOCKED = 2'd3
    } fsm_state_t;

endpackage

// File: rtl/cfd_edge_det.sv
// Registers the previous frame-clock sample and flags a low-to-high step.
module cfd_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic prev_q;

    // Reset to 1 so a line already high after reset is not an edge.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/cfd_bitpos.sv
// Position of the last captured bit inside the current frame; saturates.
module cfd_bitpos #(
    parameter int WORD_BITS = 15,
    parameter int PW        = $clog2(WORD_BITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart_i,
    output logic [PW-1:0] pos_o
);
    localparam logic [PW-1:0] LAST_POS = PW'(WORD_BITS - 1);

    logic [PW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)                    pos_q <= '0;
        else if (restart_i)         pos_q <= '0;
        else if (pos_q != LAST_POS) pos_q <= pos_q + 1'b1;
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/cfd_shifter.sv
// Right-shifting capture register: bit 0 enters at the top and ends at the LSB.
module cfd_shifter #(
    parameter int WORD_BITS = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic                 bit_i,
    output logic [WORD_BITS-1:0] word_next_o
);
    logic [WORD_BITS-1:0] shreg_q;

    always_ff @(posedge clk) begin
        if (rst)         shreg_q <= '0;
        else if (load_i) shreg_q <= {bit_i, {(WORD_BITS-1){1'b0}}};
        else             shreg_q <= {bit_i, shreg_q[WORD_BITS-1:1]};
    end

    // Word as it stands once the current bit is the last of the frame
    assign word_next_o = {bit_i, shreg_q[WORD_BITS-1:1]};
endmodule

// File: rtl/clkframe_deser.sv
module clkframe_deser
    import clkframe_deser_pkg::*;
#(
    parameter int WORD_BITS = 15,
    parameter int HIGH_LEN  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fclk_smp_i,
    input  logic                 sdata_i,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 word_valid_o,
    output logic                 frame_err_o,
    output logic                 locked_o
);
    localparam int PW = $clog2(WORD_BITS);
    localparam logic [PW-1:0] LAST_POS  = PW'(WORD_BITS - 1);
    localparam logic [PW-1:0] PENULT    = PW'(WORD_BITS - 2);
    localparam logic [PW-1:0] HIGH_LAST = PW'(HIGH_LEN - 1);

    logic                 rise;
    logic [PW-1:0]        pos_q;
    logic [WORD_BITS-1:0] word_next;

    fsm_state_t state_q, state_n;
    logic       err_n, valid_n;
    logic       exp_high, rise_bad, shape_bad, done;

    cfd_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (fclk_smp_i),
        .rise_o  (rise)
    );

    cfd_bitpos #(.WORD_BITS(WORD_BITS), .PW(PW)) u_pos (
        .clk       (clk),
        .rst       (rst),
        .restart_i (rise),
        .pos_o     (pos_q)
    );

    cfd_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_i      (rise),
        .bit_i       (sdata_i),
        .word_next_o (word_next)
    );

    // Current sample sits at position pos_q + 1 when no edge is seen
    assign exp_high  = (pos_q < HIGH_LAST);
    assign rise_bad  = rise && (pos_q != LAST_POS);
    assign shape_bad = !rise && ((pos_q == LAST_POS) || (fclk_smp_i != exp_high));
    assign done      = !rise && !shape_bad && (pos_q == PENULT);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state_q;
        err_n   = 1'b0;
        valid_n = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (rise) state_n = ST_ALIGN0;
            end
            ST_ALIGN0, ST_ALIGN1, ST_LOCKED: begin
                if (rise_bad) begin
                    state_n = ST_ALIGN0;
                    err_n   = 1'b1;
                end else if (shape_bad) begin
                    state_n = ST_HUNT;
                    err_n   = 1'b1;
                end else if (done) begin
                    valid_n = 1'b1;
                    state_n = (state_q == ST_ALIGN0) ? ST_ALIGN1 : ST_LOCKED;
                end
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            word_o       <= '0;
            word_valid_o <= 1'b0;
            frame_err_o  <= 1'b0;
            locked_o     <= 1'b0;
        end else begin
            if (valid_n) word_o <= word_next;
            word_valid_o <= valid_n;
            frame_err_o  <= err_n;
            locked_o     <= (state_n == ST_LOCKED);
        end
    end
endmodule

// File: rtl/clkframe_deser_chk.sv
module cfd_checker #(
    parameter int WORD_BITS = 15
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 fclk_smp_i,
    input logic [WORD_BITS-1:0] word_o,
    input logic                 word_valid_o,
    input logic                 frame_err_o,
    input logic                 locked_o
);
    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |=> !word_valid_o);

    // R3
    valid_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid_o |-> !$past(fclk_smp_i));

    // R7
    err_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_err_o && word_valid_o));

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> word_valid_o);

    // R8
    lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked_o) && !$past(rst)) |-> frame_err_o);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_valid_o && !$past(rst)) |-> $stable(word_o));
endmodule

bind clkframe_deser cfd_checker #(.WORD_BITS(WORD_BITS)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .fclk_smp_i   (fclk_smp_i),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .frame_err_o  (frame_err_o),
    .locked_o     (locked_o)
);

// File: tb/clkframe_deser_tb_top.sv
module clkframe_deser_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WB = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fclk_smp = 1'b0;
    logic          sdata = 1'b0;
    logic [WB-1:0] word;
    logic          word_valid, frame_err, locked;

    int            n_chk = 0;
    int            n_err = 0;
    logic [WB-1:0] last_w = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkframe_deser #(.WORD_BITS(WB), .HIGH_LEN(8)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .fclk_smp_i   (fclk_smp),
        .sdata_i      (sdata),
        .word_o       (word),
        .word_valid_o (word_valid),
        .frame_err_o  (frame_err),
        .locked_o     (locked)
    );

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Drive on the falling edge, look after the rising edge
    task automatic step(input logic fc, input logic d);
        @(negedge clk);
        fclk_smp = fc;
        sdata    = d;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [WB-1:0] gen(input int i);
        return WB'((i * 4637 + 1021) & 32'h7FFF);
    endfunction

    // One well-shaped frame; err0 = error expected on its first sample
    task automatic frame_ok(input logic [WB-1:0] w, input bit err0, input bit lock_end);
        for (int b = 0; b < WB; b++) begin
            step(b < 8, w[b]);
            if (b == 0) chk_eq("R5", "error on first sample", frame_err, err0);
            else        chk_eq("R7", "no error in clean frame", frame_err, 0);
            if (b < WB-1) begin
                chk_eq("R3", "strobe before bit 14", word_valid, 0);
                chk_eq("R9", "word held", word, last_w);
            end else begin
                chk_eq("R3", "strobe after bit 14", word_valid, 1);
                chk_eq("R3", "assembled word", word, w);
                chk_eq("R8", "lock at word", locked, lock_end);
            end
        end
        last_w = w;
    endtask

    task automatic relock(input int seed);
        frame_ok(gen(seed), 1'b0, 1'b0);
        frame_ok(gen(seed + 1), 1'b0, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        // R1 reset with the frame clock high
        rst = 1'b1;
        fclk_smp = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk_eq("R1", "word after reset", word, 0);
        chk_eq("R1", "valid after reset", word_valid, 0);
        chk_eq("R1", "err after reset", frame_err, 0);
        chk_eq("R1", "lock after reset", locked, 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2: high then long low while hunting raises nothing
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b1);
            chk_eq("R1", "high after reset not an edge", frame_err | word_valid, 0);
        end
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 1'b1);
            chk_eq("R2", "quiet while hunting", frame_err | word_valid, 0);
        end

        // R3 R8: first two frames bring lock
        relock(1);

        // R3 bit order: walking one and fixed patterns
        for (int b = 0; b < WB; b++) frame_ok(WB'(1) << b, 1'b0, 1'b1);
        frame_ok('0, 1'b0, 1'b1);
        frame_ok('1, 1'b0, 1'b1);
        frame_ok(15'h5555, 1'b0, 1'b1);
        frame_ok(15'h2AAA, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) frame_ok(gen(100 + i), 1'b0, 1'b1);

        // R4: early fall at every position 1..7
        for (int p = 1; p < 8; p++) begin
            for (int b = 0; b < WB; b++) begin
                step(b < p, b[0]);
                if (b == p) begin
                    chk_eq("R4", "early fall error", frame_err, 1);
                    chk_eq("R8", "lock drops", locked, 0);
                end else begin
                    chk_eq("R4", "no other error", frame_err, 0);
                end
                chk_eq("R4", "no word", word_valid, 0);
            end
            relock(200 + 2*p);
        end

        // R10: high run of nine
        for (int b = 0; b < WB; b++) begin
            step(b < 9, 1'b1);
            if (b == 8) begin
                chk_eq("R10", "long high error", frame_err, 1);
                chk_eq("R8", "lock drops", locked, 0);
            end else begin
                chk_eq("R10", "no other error", frame_err, 0);
            end
            chk_eq("R10", "no word", word_valid, 0);
        end
        relock(300);

        // R6: sixteenth sample still low
        step(1'b0, 1'b0);
        chk_eq("R6", "long low error", frame_err, 1);
        chk_eq("R8", "lock drops", locked, 0);
        chk_eq("R7", "no strobe with error", word_valid, 0);
        relock(310);

        // R5: early rise at positions 9..14
        for (int k = 9; k < WB; k++) begin
            for (int b = 0; b < k; b++) begin
                step(b < 8, 1'b1);
                chk_eq("R5", "prefix clean", frame_err, 0);
                chk_eq("R5", "prefix no word", word_valid, 0);
            end
            frame_ok(gen(400 + k), 1'b1, 1'b0);
            frame_ok(gen(500 + k), 1'b0, 1'b1);
        end

        // R1: reset in the middle of a frame
        for (int b = 0; b < 6; b++) step(1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk_eq("R1", "word cleared", word, 0);
        chk_eq("R1", "lock cleared", locked, 0);
        chk_eq("R1", "valid cleared", word_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b1);
        chk_eq("R1", "high after mid reset not an edge", frame_err | word_valid, 0);

        summary();
        $finish;
    end
endmodule